// File: doc/BRIEF.md
# One-Second Tick Interrupt Timer

This block divides its input clock down to a once-per-second event. It holds one 8-bit control and status register on a plain byte-wide write/read port. At each second boundary it sets a tick flag inside that register. If the stored interrupt-enable bit is set at that moment, it also raises a level interrupt towards the processor.

Software starts the timer by writing the register. Every later write restarts the second from zero, so the next boundary always falls a full period after the most recent write. Software acknowledges an interrupt by writing the register with the tick flag cleared. The number of input clock cycles in one second is a parameter. Its default suits a 32768 Hz watch crystal, and a simulation can use a small value instead.

Top module: `sec_tick_timer`

## Requirements
- R1: When a full period of CYCLES_PER_SEC clock cycles has elapsed since the interval started, bit 6 (tick flag) of the register reads 1. It reads 1 from the cycle after the CYCLES_PER_SEC-th rising edge that follows the starting write.
- R2: At a second boundary, `irq` rises on the next cycle if bit 4 (interrupt enable) of the stored register is 1. If bit 4 is 0, `irq` does not rise.
- R3: Any write restarts the interval from zero. The next boundary falls exactly CYCLES_PER_SEC cycles after the most recent write, and later boundaries follow every CYCLES_PER_SEC cycles.
- R4: A write that changes bit 6 from 1 to 0 deasserts `irq` on the following cycle.
- R5: After reset the register reads 0x00 and `irq` is 0. No boundary occurs until the first write.
- R6: A write stores all 8 bits exactly as given. `rd_data` always shows the stored value, including the current tick flag. A write that sets bit 6 directly does not raise `irq`.
- R7: If a write and a boundary fall in the same cycle, the write wins. The register holds exactly the written value, `irq` does not rise, and a new interval starts.
- R8: `irq` is a registered level. It stays 1 through writes that keep bit 6 at 1, including writes that clear bit 4. It falls only through R4 or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CYCLES_PER_SEC cycles per second |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Value written to the register |
| rd_data | output | 8 | Current register value |
| irq | output | 1 | Level interrupt request |

## Verification
The bench places a write on the exact cycle a boundary would have fired. A design that lets the boundary win would show a stray flag or a rising `irq` after the write. It restarts the interval halfway through a second and checks that the flag is still 0 one cycle before the new deadline. A timer that ignored restarts would fire early. Acknowledge writes that keep the flag set, or that only drop the enable, must leave `irq` high. A design that cleared on any write would drop it. Direct writes of the flag bit must not create an interrupt.

// File: rtl/sec_tick_pkg.sv
package sec_tick_pkg;

    localparam int REG_W      = 8;
    localparam int FLAG_POS   = 6;
    localparam int IRQ_EN_POS = 4;

    typedef logic [REG_W-1:0] reg_t;

endpackage

// File: rtl/sec_tick_prescaler.sv
module sec_tick_prescaler #(
    parameter int CYCLES_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int CNT_W = (CYCLES_PER_SEC > 1) ? $clog2(CYCLES_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES_PER_SEC - 1);

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] count;
    } state_t;

    state_t st_d, st_q;
    logic   at_last;

    always_comb begin
        st_d    = st_q;
        at_last = st_q.running && (st_q.count == LAST);
        tick    = at_last && !restart;
        if (restart) begin
            st_d.running = 1'b1;
            st_d.count   = '0;
        end else if (st_q.running) begin
            if (at_last) begin
                st_d.count = '0;
            end else begin
                st_d.count = st_q.count + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= LAST);

    p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.running && st_q.count == '0));

    p_idle_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.running |-> (st_q.count == '0));

endmodule

// File: rtl/sec_tick_ctrl.sv
module sec_tick_ctrl
    import sec_tick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  reg_t wr_data,
    input  logic tick,
    output reg_t ctrl,
    output logic irq
);

    typedef struct packed {
        reg_t ctrl;
        logic irq;
    } state_t;

    state_t st_d, st_q;
    logic   ack;

    always_comb begin
        st_d = st_q;
        ack  = wr_en && st_q.ctrl[FLAG_POS] && !wr_data[FLAG_POS];
        if (wr_en) begin
            st_d.ctrl = wr_data;
            if (ack) begin
                st_d.irq = 1'b0;
            end
        end else if (tick) begin
            st_d.ctrl[FLAG_POS] = 1'b1;
            if (st_q.ctrl[IRQ_EN_POS]) begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = st_q.ctrl;
    assign irq  = st_q.irq;

    p_tick_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ctrl[FLAG_POS]);

    p_tick_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl[IRQ_EN_POS]) |=> irq);

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl[FLAG_POS] && !wr_data[FLAG_POS]) |=> !irq);

    p_write_stores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl == $past(wr_data)));

    p_write_no_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !irq) |=> !irq);

    p_irq_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && ctrl[FLAG_POS] && !wr_data[FLAG_POS])) |=> irq);

endmodule

// File: rtl/sec_tick_timer.sv
module sec_tick_timer
    import sec_tick_pkg::*;
#(
    parameter int CYCLES_PER_SEC = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);

    logic tick;
    reg_t ctrl;

    sec_tick_prescaler #(
        .CYCLES_PER_SEC(CYCLES_PER_SEC)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(wr_en),
        .tick   (tick)
    );

    sec_tick_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .tick   (tick),
        .ctrl   (ctrl),
        .irq    (irq)
    );

    assign rd_data = ctrl;

    p_ack_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data[FLAG_POS] && !wr_data[FLAG_POS]) |=> !irq);

endmodule

// File: tb/sec_tick_timer_bench.sv
module sec_tick_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R5";

    // behavioural reference
    int       m_started = 0;
    int       m_phase = 0;
    int       m_reg = 0;
    int       m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_tick_timer #(.CYCLES_PER_SEC(CYC)) u_sec_tick_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .irq    (irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 0; m_phase = 0; m_reg = 0; m_irq = 0;
        end else if (wr_en) begin
            if (((m_reg >> 6) & 1) == 1 && wr_data[6] == 1'b0) m_irq = 0;
            m_reg = int'(wr_data);
            m_phase = 0;
            m_started = 1;
        end else if (m_started == 1) begin
            m_phase = m_phase + 1;
            if (m_phase == CYC) begin
                m_phase = 0;
                m_reg = m_reg | 32'h40;
                if (((m_reg >> 4) & 1) == 1) m_irq = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(rd_data) != m_reg || int'(irq) != m_irq) begin
                errors++;
                $display("FAIL %s model: rd=%02h irq=%0d expected rd=%02h irq=%0d",
                         cur_tag, rd_data, irq, m_reg[7:0], m_irq);
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] exp_rd, input logic exp_irq);
        checks++;
        if (rd_data !== exp_rd || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: rd=%02h irq=%0b expected rd=%02h irq=%0b",
                     tag, rd_data, irq, exp_rd, exp_irq);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R5";
        check("R5 reset", 8'h00, 1'b0);
        idle(3 * CYC);
        check("R5 no tick before write", 8'h00, 1'b0);

        cur_tag = "R1";
        wr(8'h10);
        idle(CYC - 1);
        check("R1 before boundary", 8'h10, 1'b0);
        idle(1);
        check("R1 R2 at boundary", 8'h50, 1'b1);

        cur_tag = "R8";
        wr(8'h50);
        check("R8 keep flag", 8'h50, 1'b1);
        wr(8'h40);
        check("R8 enable off", 8'h40, 1'b1);
        cur_tag = "R4";
        wr(8'h00);
        check("R4 ack", 8'h00, 1'b0);

        cur_tag = "R3";
        wr(8'h10);
        idle(CYC / 2);
        wr(8'h10);
        idle(CYC - 1);
        check("R3 restarted early", 8'h10, 1'b0);
        idle(1);
        check("R3 boundary after restart", 8'h50, 1'b1);
        idle(CYC);
        check("R3 repeat", 8'h50, 1'b1);
        wr(8'h00);
        check("R4 ack again", 8'h00, 1'b0);
        idle(CYC - 1);
        check("R3 period", 8'h00, 1'b0);
        idle(1);
        cur_tag = "R2";
        check("R2 disabled no irq", 8'h40, 1'b0);

        cur_tag = "R7";
        wr(8'h10);
        idle(CYC - 1);
        wr(8'h33);
        check("R7 write beats tick", 8'h33, 1'b0);
        idle(CYC - 1);
        check("R7 new interval", 8'h33, 1'b0);
        idle(1);
        check("R7 tick after collision", 8'h73, 1'b1);
        wr(8'h00);

        cur_tag = "R6";
        wr(8'hA5);
        check("R6 store", 8'hA5, 1'b0);
        wr(8'hFF);
        check("R6 direct flag no irq", 8'hFF, 1'b0);
        wr(8'h00);
        check("R6 clear", 8'h00, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule